// File: doc/BRIEF.md
# TDM Serial Output with Sub-Bit Advancement

This block drives one time-division-multiplexed serial output line. A frame holds a number of 8-bit channels, and each byte is sent most significant bit first. A single-tick frame strobe marks the frame boundary. The block runs from a 32.768 MHz master clock, and one frame always lasts 4096 ticks. A 2-bit rate select picks one of four line rates: 2.048, 4.096, 8.192 or 16.384 Mbit/s. A bit therefore lasts 16, 8, 4 or 2 ticks, and a frame holds 32, 64, 128 or 256 channels.

A 2-bit advancement code moves the whole output stream earlier than its nominal frame-aligned position by a fraction of a bit. This lets a board compensate for different capacitive loading on the output pin. Every bit of every channel moves by the same amount. As a result, the first bit of channel 0 starts in the tail of the previous frame's last channel.

The block asks its byte source for data with a channel index, one bit period before the byte is needed. It reads the byte on the data input at the start of the advanced channel. New rate and advancement settings are captured only on a frame strobe.

Top module: `tdm_sout`

## Requirements
- R1: While reset is asserted, `ser_out` is 0 and `ch_req` is 0.
- R2: With zero advancement, the tick right after the frame strobe edge carries bit 7 of channel 0. Bits follow MSB first. Each bit holds for 16, 8, 4 or 2 ticks for rate codes 0, 1, 2, 3 (2.048, 4.096, 8.192, 16.384 Mbit/s).
- R3: A frame is 4096 ticks. The last channel index is 31, 63, 127 or 255 for rate codes 0, 1, 2, 3.
- R4: At rate codes 0 to 2, advancement codes 0, 1, 2 and 3 move the stream earlier by 0, 1/4, 1/2 and 3/4 of a bit. That is the code times 4, 2 or 1 ticks.
- R5: At rate code 3, advancement code 1 moves the stream earlier by half a bit (1 tick). Codes 0, 2 and 3 give no advancement.
- R6: With advancement of A ticks, bit 7 of channel 0 begins A ticks before the frame strobe edge, inside the last channel of the previous frame.
- R7: On every tick, `ch_req` holds the index of the channel that contains the stream position one bit period later. The byte on `ch_byte` is taken at the first tick of each advanced channel.
- R8: Changes on `rate_sel` and `adv_code` between frame strobes have no effect on the output until the next strobe.
- R9: `ser_out` changes only at bit-period boundaries of the advanced stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | Single-tick frame boundary strobe, active high |
| rate_sel | input | 2 | Line rate code 0..3 (2.048 to 16.384 Mbit/s) |
| adv_code | input | 2 | Fractional advancement code |
| ch_byte | input | 8 | Byte for the requested channel |
| ch_req | output | 8 | Index of the channel whose byte is wanted |
| ser_out | output | 1 | Serial data line |

## Verification
Each of the 16 combinations of rate and advancement code is run over a full frame. Each channel carries a different byte, built from its index. Every tick is compared with an arithmetic model of the advanced position. Any offset error of even one tick, or a wrong bit or channel order, shows up as a mismatch. The 16.384 Mbit/s codes 2 and 3 are expected to match the zero-advancement case, which separates them from a plain quarter-bit decoding. Halfway through each frame, the rate and code inputs are inverted. This shows that the output ignores them until the next strobe. The request index is checked on every tick to confirm that it runs one bit ahead.

// File: rtl/tdm_sout_pkg.sv
package tdm_sout_pkg;

  typedef enum logic [1:0] {
    RATE_2M  = 2'd0,
    RATE_4M  = 2'd1,
    RATE_8M  = 2'd2,
    RATE_16M = 2'd3
  } rate_e;

  // log2 of ticks per bit for a rate, given log2 ticks of the slowest rate
  function automatic int unsigned bit_shift(input rate_e r, input int unsigned slow_log2);
    return slow_log2 - int'(r);
  endfunction

endpackage

// File: rtl/tdm_cfg.sv
module tdm_cfg
  import tdm_sout_pkg::*;
#(
  parameter int unsigned SLOW_LOG2 = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fp,
  input  logic [1:0]           rate_sel,
  input  logic [1:0]           adv_code,
  output rate_e                rate_q,
  output logic [SLOW_LOG2-1:0] adv_q,
  output rate_e                rate_nx,
  output logic [SLOW_LOG2-1:0] adv_nx
);

  rate_e                rate_in;
  logic [SLOW_LOG2-1:0] adv_calc;
  int unsigned          ts;

  always_comb begin
    rate_in  = rate_e'(rate_sel);
    ts       = bit_shift(rate_in, SLOW_LOG2);
    adv_calc = '0;
    if (ts >= 2) begin
      // quarter bit is 2**(ts-2) ticks
      adv_calc = SLOW_LOG2'(adv_code) << (ts - 2);
    end else if (ts == 1) begin
      // only half a bit (one tick) exists
      adv_calc = (adv_code == 2'd1) ? SLOW_LOG2'(1) : '0;
    end
  end

  always_comb begin
    rate_nx = rate_q;
    adv_nx  = adv_q;
    if (fp) begin
      rate_nx = rate_in;
      adv_nx  = adv_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_2M;
      adv_q  <= '0;
    end else if (fp) begin
      rate_q <= rate_nx;
      adv_q  <= adv_nx;
    end
  end

endmodule

// File: rtl/tdm_pos.sv
module tdm_pos
  import tdm_sout_pkg::*;
#(
  parameter int unsigned SLOW_LOG2   = 4,
  parameter int unsigned CH_MIN_LOG2 = 5,
  parameter int unsigned CH_W        = CH_MIN_LOG2 + 3,
  parameter int unsigned POS_W       = CH_MIN_LOG2 + 3 + SLOW_LOG2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fp,
  input  rate_e                rate_q,
  input  rate_e                rate_nx,
  input  logic [SLOW_LOG2-1:0] adv_nx,
  output logic [POS_W-1:0]     pos_q,
  output logic                 bit_start,
  output logic                 chan_start,
  output logic [CH_W-1:0]      ch_req
);

  logic [POS_W-1:0] pos_nx;
  logic [POS_W-1:0] bit_mask;
  logic [POS_W-1:0] chan_mask;
  logic [POS_W-1:0] ahead;
  int unsigned      ts_nx;
  int unsigned      ts_q;

  // next position and the boundaries it opens
  always_comb begin
    pos_nx     = fp ? POS_W'(adv_nx) : pos_q + POS_W'(1);
    ts_nx      = bit_shift(rate_nx, SLOW_LOG2);
    bit_mask   = (POS_W'(1) << ts_nx) - POS_W'(1);
    chan_mask  = (POS_W'(1) << (ts_nx + 3)) - POS_W'(1);
    bit_start  = (pos_nx & bit_mask) == '0;
    chan_start = (pos_nx & chan_mask) == '0;
  end

  // request index: channel one bit period ahead of the present position
  always_comb begin
    ts_q   = bit_shift(rate_q, SLOW_LOG2);
    ahead  = pos_q + (POS_W'(1) << ts_q);
    ch_req = CH_W'(ahead >> (ts_q + 3));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else begin
      pos_q <= pos_nx;
    end
  end

endmodule

// File: rtl/tdm_shift.sv
module tdm_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_start,
  input  logic       bit_start,
  input  logic [7:0] ch_byte,
  output logic       sdo
);

  logic [7:0] sreg_q;
  logic [7:0] sreg_nx;
  logic       sreg_en;

  always_comb begin
    sreg_en = chan_start | bit_start;
    sreg_nx = chan_start ? ch_byte : {sreg_q[6:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else if (sreg_en) begin
      sreg_q <= sreg_nx;
    end
  end

  assign sdo = sreg_q[7];

endmodule

// File: rtl/tdm_sout.sv
module tdm_sout
  import tdm_sout_pkg::*;
#(
  parameter int unsigned SLOW_LOG2   = 4,
  parameter int unsigned CH_MIN_LOG2 = 5,
  localparam int unsigned CH_W       = CH_MIN_LOG2 + 3,
  localparam int unsigned POS_W      = CH_MIN_LOG2 + 3 + SLOW_LOG2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_pulse,
  input  logic [1:0]      rate_sel,
  input  logic [1:0]      adv_code,
  input  logic [7:0]      ch_byte,
  output logic [CH_W-1:0] ch_req,
  output logic            ser_out
);

  logic                 rst_s1_q;
  logic                 rst_sync_n;
  rate_e                rate_q;
  rate_e                rate_nx;
  logic [SLOW_LOG2-1:0] adv_q;
  logic [SLOW_LOG2-1:0] adv_nx;
  logic [POS_W-1:0]     pos_q;
  logic                 bit_start;
  logic                 chan_start;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  tdm_cfg #(.SLOW_LOG2(SLOW_LOG2)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .fp       (frame_pulse),
    .rate_sel (rate_sel),
    .adv_code (adv_code),
    .rate_q   (rate_q),
    .adv_q    (adv_q),
    .rate_nx  (rate_nx),
    .adv_nx   (adv_nx)
  );

  tdm_pos #(
    .SLOW_LOG2   (SLOW_LOG2),
    .CH_MIN_LOG2 (CH_MIN_LOG2),
    .CH_W        (CH_W),
    .POS_W       (POS_W)
  ) u_pos (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fp         (frame_pulse),
    .rate_q     (rate_q),
    .rate_nx    (rate_nx),
    .adv_nx     (adv_nx),
    .pos_q      (pos_q),
    .bit_start  (bit_start),
    .chan_start (chan_start),
    .ch_req     (ch_req)
  );

  tdm_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .chan_start (chan_start),
    .bit_start  (bit_start),
    .ch_byte    (ch_byte),
    .sdo        (ser_out)
  );

endmodule

// File: rtl/tdm_sout_chk.sv
module tdm_sout_chk #(
  parameter int unsigned SLOW_LOG2 = 4,
  parameter int unsigned POS_W     = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fp,
  input logic [1:0]           rate,
  input logic [SLOW_LOG2-1:0] adv,
  input logic [POS_W-1:0]     pos,
  input logic                 sdo
);

  logic [POS_W-1:0] tpb;
  logic [POS_W-1:0] quarter;

  always_comb begin
    tpb     = POS_W'(1) << (SLOW_LOG2 - 32'(rate));
    quarter = tpb >> 2;
  end

  // R2
  first_bit_after_fp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> (pos < tpb));

  // R3
  pos_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fp |=> (pos == $past(pos) + POS_W'(1)));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fp |=> ($stable(rate) && $stable(adv)));

  // R4
  quarter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate != 2'd3) |-> ((POS_W'(adv) & (quarter - POS_W'(1))) == '0 && POS_W'(adv) < tpb));

  // R5
  fast_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == 2'd3) |-> (adv <= SLOW_LOG2'(1)));

  // R9
  mid_bit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pos & (tpb - POS_W'(1))) != '0) |-> $stable(sdo));

endmodule

bind tdm_sout tdm_sout_chk #(.SLOW_LOG2(SLOW_LOG2), .POS_W(POS_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .fp    (frame_pulse),
  .rate  (rate_q),
  .adv   (adv_q),
  .pos   (pos_q),
  .sdo   (ser_out)
);

// File: tb/tdm_sout_tb.sv
module tdm_sout_tb;

  localparam time CLK_PERIOD = 30ns;
  localparam int  FRAME      = 4096;
  localparam int  WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_pulse;
  logic [1:0] rate_sel;
  logic [1:0] adv_code;
  logic [7:0] ch_byte;
  logic [7:0] ch_req;
  logic       ser_out;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_sout u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_pulse (frame_pulse),
    .rate_sel    (rate_sel),
    .adv_code    (adv_code),
    .ch_byte     (ch_byte),
    .ch_req      (ch_req),
    .ser_out     (ser_out)
  );

  function automatic logic [7:0] pat(input int ch);
    return 8'((ch * 29 + 90) & 255) ^ 8'(ch >> 3);
  endfunction

  always_comb ch_byte = pat(int'(ch_req));

  function automatic int adv_ticks(input int r, input int c);
    if (r < 3) return c << (2 - r);
    return (c == 1) ? 1 : 0;
  endfunction

  task automatic check(input string tag, input int bad, input int act, input int exp);
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: %0d mismatching ticks, first actual %0d expected %0d", tag, bad, act, exp);
    end
  endtask

  // one frame; at entry the bench stands at a negedge before the strobe edge
  task automatic frame(input int r, input int c, input bit chk);
    int ts, a, bad_d, bad_l, bad_q, fa_d, fe_d, fa_l, fe_l, fa_q, fe_q;
    ts = 4 - r;
    a  = adv_ticks(r, c);
    bad_d = 0; bad_l = 0; bad_q = 0;
    fa_d = 0; fe_d = 0; fa_l = 0; fe_l = 0; fa_q = 0; fe_q = 0;
    frame_pulse = 1'b1;
    rate_sel    = 2'(r);
    adv_code    = 2'(c);
    for (int k = 0; k < FRAME; k++) begin
      int p, ch, bn, eq;
      logic ed;
      @(negedge clk);
      frame_pulse = 1'b0;
      if (chk && k == 2000) begin
        // R8: inputs change mid-frame and must be ignored
        rate_sel = ~2'(r);
        adv_code = ~2'(c);
      end
      p  = (a + k) % FRAME;
      ch = p >> (ts + 3);
      bn = 7 - ((p >> ts) & 7);
      ed = pat(ch)[bn];
      eq = ((p + (1 << ts)) % FRAME) >> (ts + 3);
      if (chk) begin
        if (ser_out !== ed) begin
          if (k < 2000) begin
            if (bad_d == 0) begin fa_d = int'(ser_out); fe_d = int'(ed); end
            bad_d++;
          end else begin
            if (bad_l == 0) begin fa_l = int'(ser_out); fe_l = int'(ed); end
            bad_l++;
          end
        end
        if (int'(ch_req) != eq) begin
          if (bad_q == 0) begin fa_q = int'(ch_req); fe_q = eq; end
          bad_q++;
        end
      end
    end
    if (chk) begin
      if (c == 0 || (r == 3 && c != 1))
        check($sformatf("R2 R3 R5 R9 rate=%0d code=%0d", r, c), bad_d, fa_d, fe_d);
      else if (r == 3)
        check($sformatf("R5 R6 R9 rate=%0d code=%0d", r, c), bad_d, fa_d, fe_d);
      else
        check($sformatf("R4 R6 R9 rate=%0d code=%0d", r, c), bad_d, fa_d, fe_d);
      check($sformatf("R8 rate=%0d code=%0d", r, c), bad_l, fa_l, fe_l);
      check($sformatf("R7 rate=%0d code=%0d", r, c), bad_q, fa_q, fe_q);
    end
  endtask

  initial begin
    rst_n       = 1'b0;
    frame_pulse = 1'b0;
    rate_sel    = 2'd0;
    adv_code    = 2'd0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 ser_out in reset", int'(ser_out !== 1'b0), int'(ser_out), 0);
    check("R1 ch_req in reset", int'(ch_req !== 8'd0), int'(ch_req), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        frame(r, c, 1'b0);  // settle under the new setting
        frame(r, c, 1'b1);
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule